// File: doc/BRIEF.md
# Relocatable Legacy I/O Function Decoder

This block holds the configuration registers that decide which legacy peripheral functions answer on a 16-bit I/O bus, and at which base address each one answers. The functions are a floppy controller, a parallel port and one or two serial ports. Software reaches the registers through a two-byte port. A write with the select bit low loads a register index. A write with the select bit high stores a byte into the register that index points at.

On every clock the block compares the incoming I/O address against the 8-byte window of each enabled function. It registers a one-hot chip select and the byte offset inside the chosen window. When windows overlap, a fixed priority picks one function. A parameter builds the single-serial variant. In that variant the whole register set moves up by 0x10 and the second serial port does not exist.

Top module: `sio_cfg_decoder`

## Requirements
- R1: A write with `cfg_sel`=0 loads the index register. A write with `cfg_sel`=1 stores `cfg_wdata` into the register the index selects. With `cfg_sel`=0, `cfg_rdata` returns the index. With `cfg_sel`=1, it returns the selected register.
- R2: After reset the index is 0x00 and the register block reads as follows, with offsets taken from its base (0xE0 by default, 0xF0 in the variant): +0 = 0x3C (identifier), +2 = 0x0F (0x07 in the variant), +3 = 0xFC, +6 = 0xDE, +7 = 0xFE, +8 = 0xBE (two-port build only).
- R3: Register +2 is the function select. The parallel port is on unless bits [1:0] are 3. Bit 2 turns on serial 1, bit 3 turns on serial 2 and bit 4 turns on the floppy controller. A function that is off never gets a chip select.
- R4: The base addresses are: floppy = reg(+3)·4, parallel = reg(+6)·4, serial 1 = reg(+7)·4 and serial 2 = reg(+8)·4. Each uses the stored, masked value.
- R5: Reserved bits are stored as 0 and read back as 0. These are function-select bits 7:5 (and bit 3 in the variant), floppy-base bits 1:0, and serial-base bit 0.
- R6: The identifier at +0 is read-only. Every index without a register, 0xFD to 0xFF included, reads 0x00. A write to any of these indices changes nothing.
- R7: A function hits when its enable is set and address − base lies in 0..7. `io_off` is then address − base.
- R8: `io_cs` and `io_off` are registered. They reflect the address and the register contents present at the previous rising edge, so a configuration write takes effect in the cycle after its edge.
- R9: When no window hits, `io_cs` and `io_off` are both 0.
- R10: When windows overlap, the winner follows the priority floppy, then serial 1, then serial 2, then parallel. The `io_cs` bits are 0 = floppy, 1 = serial 1, 2 = serial 2, 3 = parallel.
- R11: With `SER_PORTS`=1 the registers sit at 0xF0 + offset, index +8 is unimplemented, and `io_cs[2]` never asserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = index byte, 1 = data byte |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Index (sel 0) or selected register (sel 1) |
| io_addr | input | ADDR_W | I/O bus address to decode |
| io_cs | output | 4 | Registered one-hot function select |
| io_off | output | WIN_W | Registered offset inside the window |

## Verification
The bench builds two instances side by side on shared inputs. One uses `SER_PORTS`=2 and the other `SER_PORTS`=1. A data write therefore lands on a live register in one instance and on an unimplemented index in the other. Both instances are read back over the whole 0xE0–0xFF index range. Address sweeps cover 0x000–0x40F, which reaches every window the 8-bit base fields can place. The sweeps repeat under several enable patterns, including stacked and partly overlapping windows, a parallel base that is not 8-aligned, and all four parallel mode values.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int NFUNC  = 4;
  // function slots, also the priority order (lowest index wins)
  localparam int FN_FDC = 0;
  localparam int FN_S1  = 1;
  localparam int FN_S2  = 2;
  localparam int FN_PAR = 3;
  localparam logic [7:0] DEV_ID = 8'h3C;
endpackage

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_pkg::*;
#(
  parameter int SER_PORTS = 2,
  parameter int ADDR_W    = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic                           cfg_sel,
  input  logic [7:0]                     cfg_wdata,
  output logic [7:0]                     cfg_rdata,
  output logic [NFUNC-1:0]               fn_en,
  output logic [NFUNC-1:0][ADDR_W-1:0]   win_base
);
  localparam bit         TWO_SER = (SER_PORTS > 1);
  localparam logic [7:0] RBASE   = TWO_SER ? 8'hE0 : 8'hF0;
  localparam logic [7:0] IX_ID   = RBASE;
  localparam logic [7:0] IX_FSEL = RBASE + 8'd2;
  localparam logic [7:0] IX_FDC  = RBASE + 8'd3;
  localparam logic [7:0] IX_PAR  = RBASE + 8'd6;
  localparam logic [7:0] IX_S1   = RBASE + 8'd7;
  localparam logic [7:0] IX_S2   = RBASE + 8'd8;
  localparam logic [7:0] FSEL_M  = TWO_SER ? 8'h1F : 8'h17;
  localparam logic [7:0] FDC_M   = 8'hFC;
  localparam logic [7:0] SER_M   = 8'hFE;
  localparam int         PADW    = ADDR_W - 10;

  logic [7:0] idx_q, fsel_q, fdc_q, par_q, s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= 8'h00;
      fsel_q <= 8'h0F & FSEL_M;
      fdc_q  <= 8'hFC;
      par_q  <= 8'hDE;
      s1_q   <= 8'hFE;
      s2_q   <= TWO_SER ? 8'hBE : 8'h00;
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        idx_q <= cfg_wdata;
      end else begin
        if (idx_q == IX_FSEL) fsel_q <= cfg_wdata & FSEL_M;
        if (idx_q == IX_FDC)  fdc_q  <= cfg_wdata & FDC_M;
        if (idx_q == IX_PAR)  par_q  <= cfg_wdata;
        if (idx_q == IX_S1)   s1_q   <= cfg_wdata & SER_M;
        if (TWO_SER && idx_q == IX_S2) s2_q <= cfg_wdata & SER_M;
      end
    end
  end

  logic [7:0] reg_rd;
  always_comb begin
    reg_rd = 8'h00;
    if (idx_q == IX_ID)   reg_rd = DEV_ID;
    if (idx_q == IX_FSEL) reg_rd = fsel_q;
    if (idx_q == IX_FDC)  reg_rd = fdc_q;
    if (idx_q == IX_PAR)  reg_rd = par_q;
    if (idx_q == IX_S1)   reg_rd = s1_q;
    if (TWO_SER && idx_q == IX_S2) reg_rd = s2_q;
  end
  assign cfg_rdata = cfg_sel ? reg_rd : idx_q;

  always_comb begin
    fn_en[FN_FDC] = fsel_q[4];
    fn_en[FN_S1]  = fsel_q[2];
    fn_en[FN_S2]  = TWO_SER && fsel_q[3];
    fn_en[FN_PAR] = (fsel_q[1:0] != 2'b11);
    win_base[FN_FDC] = {{PADW{1'b0}}, fdc_q, 2'b00};
    win_base[FN_S1]  = {{PADW{1'b0}}, s1_q,  2'b00};
    win_base[FN_S2]  = {{PADW{1'b0}}, s2_q,  2'b00};
    win_base[FN_PAR] = {{PADW{1'b0}}, par_q, 2'b00};
  end
endmodule

// File: rtl/sio_window.sv
module sio_window #(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              en,
  output logic              hit,
  output logic [WIN_W-1:0]  off
);
  logic [ADDR_W-1:0] diff;
  assign diff = addr - base;
  assign hit  = en && (diff[ADDR_W-1:WIN_W] == '0);
  assign off  = diff[WIN_W-1:0];
endmodule

// File: rtl/sio_prio.sv
module sio_prio #(
  parameter int N     = 4,
  parameter int WIN_W = 3
) (
  input  logic [N-1:0]            hit,
  input  logic [N-1:0][WIN_W-1:0] off_in,
  output logic [N-1:0]            sel,
  output logic [WIN_W-1:0]        off_out
);
  always_comb begin
    sel     = '0;
    off_out = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel     = '0;
        sel[i]  = 1'b1;
        off_out = off_in[i];
      end
    end
  end
endmodule

// File: rtl/sio_cfg_decoder.sv
module sio_cfg_decoder
  import sio_pkg::*;
#(
  parameter int SER_PORTS = 2,
  parameter int ADDR_W    = 16,
  parameter int WIN_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] io_addr,
  output logic [3:0]        io_cs,
  output logic [WIN_W-1:0]  io_off
);
  logic [NFUNC-1:0]             fn_en;
  logic [NFUNC-1:0][ADDR_W-1:0] win_base;
  logic [NFUNC-1:0]             hit;
  logic [NFUNC-1:0][WIN_W-1:0]  woff;
  logic [NFUNC-1:0]             sel_c;
  logic [WIN_W-1:0]             off_c;

  sio_regfile #(.SER_PORTS(SER_PORTS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fn_en(fn_en), .win_base(win_base)
  );

  for (genvar g = 0; g < NFUNC; g++) begin : g_win
    sio_window #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_win (
      .addr(io_addr), .base(win_base[g]), .en(fn_en[g]),
      .hit(hit[g]), .off(woff[g])
    );
  end

  sio_prio #(.N(NFUNC), .WIN_W(WIN_W)) u_prio (
    .hit(hit), .off_in(woff), .sel(sel_c), .off_out(off_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_cs  <= '0;
      io_off <= '0;
    end else begin
      io_cs  <= sel_c;
      io_off <= off_c;
    end
  end
endmodule

// File: rtl/sio_cfg_decoder_chk.sv
module sio_cfg_decoder_chk
  import sio_pkg::*;
#(
  parameter int SER_PORTS = 2,
  parameter int WIN_W     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             cfg_sel,
  input logic [7:0]       cfg_wdata,
  input logic [7:0]       cfg_rdata,
  input logic [3:0]       io_cs,
  input logic [WIN_W-1:0] io_off,
  input logic [NFUNC-1:0] fn_en,
  input logic [NFUNC-1:0] hit
);
  // R7
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(io_cs));

  // R9
  miss_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |=> (io_cs == '0 && io_off == '0));

  // R1
  index_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_sel) |=> (cfg_sel || cfg_rdata == $past(cfg_wdata)));

  for (genvar i = 0; i < NFUNC; i++) begin : g_fn
    localparam logic [NFUNC-1:0] HIGHER = NFUNC'((1 << i) - 1);
    // R3
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
      io_cs[i] |-> $past(fn_en[i]));
    // R10
    prio_order_chk: assert property (@(posedge clk) disable iff (rst)
      io_cs[i] |-> (($past(hit) & HIGHER) == '0));
  end

  if (SER_PORTS == 1) begin : g_one
    // R11
    no_ser2_chk: assert property (@(posedge clk) disable iff (rst)
      !io_cs[FN_S2]);
  end
endmodule

bind sio_cfg_decoder sio_cfg_decoder_chk #(.SER_PORTS(SER_PORTS), .WIN_W(WIN_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_cs(io_cs),
  .io_off(io_off), .fn_en(fn_en), .hit(hit)
);

// File: tb/sio_cfg_decoder_bench.sv
module sio_cfg_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  rd_a, rd_b;
  logic [3:0]  cs_a, cs_b;
  logic [2:0]  off_a, off_b;

  int total = 0;
  int bad = 0;
  int cur_idx = 0;
  int sh[2][5];  // per build: fsel, fdc, par, ser1, ser2

  always #5 clk = ~clk;

  sio_cfg_decoder #(.SER_PORTS(2)) u_sio_cfg_decoder (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a), .io_addr(io_addr),
    .io_cs(cs_a), .io_off(off_a));

  sio_cfg_decoder #(.SER_PORTS(1)) u_var (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b), .io_addr(io_addr),
    .io_cs(cs_b), .io_off(off_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int slot(input int inst, input int idx);
    int rel = idx - (inst == 1 ? 'hF0 : 'hE0);
    case (rel)
      2: return 0;
      3: return 1;
      6: return 2;
      7: return 3;
      8: return (inst == 0) ? 4 : -1;
      default: return -1;
    endcase
  endfunction

  function automatic int fmask(input int inst, input int k);
    case (k)
      0: return (inst == 1) ? 'h17 : 'h1F;
      1: return 'hFC;
      2: return 'hFF;
      default: return 'hFE;
    endcase
  endfunction

  function automatic int exp_rd(input int inst, input int idx);
    int s = slot(inst, idx);
    if (idx == (inst == 1 ? 'hF0 : 'hE0)) return 'h3C;
    if (s < 0) return 0;
    return sh[inst][s];
  endfunction

  // returns cs<<8 | off
  function automatic int exp_dec(input int inst, input int a);
    int en[4];
    int b[4];
    en[0] = (sh[inst][0] >> 4) & 1;
    en[1] = (sh[inst][0] >> 2) & 1;
    en[2] = (inst == 0) ? ((sh[inst][0] >> 3) & 1) : 0;
    en[3] = ((sh[inst][0] & 3) != 3) ? 1 : 0;
    b[0] = sh[inst][1] * 4;
    b[1] = sh[inst][3] * 4;
    b[2] = sh[inst][4] * 4;
    b[3] = sh[inst][2] * 4;
    for (int k = 0; k < 4; k++)
      if (en[k] != 0 && a >= b[k] && a < b[k] + 8)
        return ((1 << k) << 8) | (a - b[k]);
    return 0;
  endfunction

  task automatic model_reset();
    sh[0][0] = 'h0F; sh[0][1] = 'hFC; sh[0][2] = 'hDE; sh[0][3] = 'hFE; sh[0][4] = 'hBE;
    sh[1][0] = 'h07; sh[1][1] = 'hFC; sh[1][2] = 'hDE; sh[1][3] = 'hFE; sh[1][4] = 0;
    cur_idx = 0;
  endtask

  task automatic model_write(input bit sel, input int d);
    if (!sel) cur_idx = d;
    else
      for (int inst = 0; inst < 2; inst++) begin
        int s = slot(inst, cur_idx);
        if (s >= 0) sh[inst][s] = d & fmask(inst, s);
      end
  endtask

  task automatic wr(input bit sel, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(sel, d);
  endtask

  task automatic setreg(input int idx, input int d);
    wr(1'b0, idx);
    wr(1'b1, d);
  endtask

  task automatic read_all(input string req);
    for (int i = 'hE0; i <= 'hFF; i++) begin
      wr(1'b0, i);
      cfg_sel = 1'b0;
      #1;
      chk(rd_a == i[7:0], "R1 index readback", rd_a, i);
      cfg_sel = 1'b1;
      #1;
      chk(rd_a == exp_rd(0, i), req, rd_a, exp_rd(0, i));
      chk(rd_b == exp_rd(1, i), {req, " R11 variant"}, rd_b, exp_rd(1, i));
    end
  endtask

  task automatic sweep(input int lo, input int hi, input string req);
    for (int a = lo; a <= hi; a++) begin
      int ea, eb;
      @(negedge clk);
      io_addr = a[15:0];
      @(negedge clk);
      ea = exp_dec(0, a);
      eb = exp_dec(1, a);
      chk({cs_a, 5'b0, off_a} == ea[11:0], req, {cs_a, 5'b0, off_a}, ea);
      chk({cs_b, 5'b0, off_b} == eb[11:0], {req, " R11"}, {cs_b, 5'b0, off_b}, eb);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    cfg_sel = 1'b0; #1;
    chk(rd_a == 8'h00, "R2 index reset", rd_a, 0);
    chk(cs_a == 4'h0 && cs_b == 4'h0, "R2 cs reset", {cs_a, cs_b}, 0);
    read_all("R2 reset value");
    sweep(0, 'h40F, "R2 R3 R7 reset decode");

    // R6 writes to read-only and unimplemented indices
    setreg('hE0, 'h55); setreg('hF0, 'h55); setreg('hE1, 'hFF);
    setreg('hE4, 'hFF); setreg('hE9, 'hFF); setreg('hF9, 'hFF);
    setreg('hFD, 'hFF); setreg('hFE, 'hFF); setreg('hFF, 'hFF);
    read_all("R6 ignored write");

    // R5 masking, R4 base formulas
    setreg('hE2, 'hFF); setreg('hF2, 'hFF);
    setreg('hE3, 'hFF); setreg('hF3, 'hFF);
    setreg('hE7, 'h7F); setreg('hF7, 'h7F);
    setreg('hE8, 'h5F); setreg('hF8, 'h5F);
    setreg('hE6, 'hDF); setreg('hF6, 'hDF);
    read_all("R5 masked readback");
    setreg('hE2, 'h1C); setreg('hF2, 'h16);
    sweep(0, 'h40F, "R4 R7 relocated decode");

    // R10 stacked and partly overlapping windows
    setreg('hE3, 'hF0); setreg('hF3, 'hF0);
    setreg('hE7, 'hF0); setreg('hF7, 'hF0);
    setreg('hE8, 'hF0);
    setreg('hE6, 'hF1); setreg('hF6, 'hF1);
    setreg('hE2, 'h1D); setreg('hF2, 'h15);
    sweep('h3A0, 'h3FF, "R10 all on");
    setreg('hE2, 'h0E); setreg('hF2, 'h06);
    sweep('h3A0, 'h3FF, "R10 floppy off");
    setreg('hE2, 'h0B); setreg('hF2, 'h00);
    sweep('h3A0, 'h3FF, "R3 R10 serial2 only");
    setreg('hE2, 'h03); setreg('hF2, 'h03);
    sweep('h3A0, 'h3FF, "R3 R9 all off");

    // R7 upper address bits must match too
    setreg('hE2, 'h1F);
    @(negedge clk); io_addr = 16'h83C0;
    @(negedge clk);
    chk(cs_a == 4'h0 && off_a == 3'd0, "R7 R9 high address miss", cs_a, 0);

    // R8 enable write takes effect one cycle after its edge
    setreg('hE2, 'h03);
    @(negedge clk); io_addr = 16'h03C0;
    @(negedge clk);
    chk(cs_a == 4'h0, "R8 before write", cs_a, 0);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h13;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(1'b1, 'h13);
    chk(cs_a == 4'h0, "R8 same cycle as write", cs_a, 0);
    @(negedge clk);
    chk(cs_a == 4'h1 && off_a == 3'd0, "R8 cycle after write", cs_a, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule